// File: doc/BRIEF.md
# Bus Slave Access Guard

This block sits between a system interconnect and a set of slave register regions. It screens every transaction before it reaches a slave. Each request carries a master identifier, a direction, a privilege flag and an address. The block decodes the address to one of four regions using a base/mask pair per region. It then either forwards the request in the same cycle or rejects it and returns a one-cycle error response of its own.

Two rules cause a rejection. The first applies to region 0, the power-management control region: only the master with identifier 1 may write it, although every master may read it. A registered debug-mode input lifts that identifier check. The second applies to every region: when the power-domain-on input of the target region reads low, any access to it is refused, reads and writes alike. The power rule wins when both rules apply. Each rejection is recorded in a sticky status register, which software clears with a one-cycle pulse.

Top module: `slave_access_guard`

## Requirements
- R1: Region i matches when `(addr & MASK[i]) == BASE[i]`. `slv_sel_o` is one-hot, and the lowest-numbered matching region wins. An address that matches no region is forwarded with an all-zero select.
- R2: A write to region 0 whose master identifier is not 1, made while debug mode is inactive, is not forwarded. It is accepted with `req_ready_o`=1 and receives an error response one cycle later with cause code 2'b10.
- R3: Reads of region 0 from any master, and writes of region 0 from master identifier 1, are forwarded like any other permitted access.
- R4: While the registered debug mode is active, writes to region 0 from any master identifier are forwarded. `dbg_mode_i` takes effect one cycle after it changes.
- R5: Any access to a matched region whose registered power-on bit is 0 is not forwarded and receives an error response with cause 2'b01. `pwr_on_i` takes effect one cycle after it changes, and reset treats every domain as on.
- R6: When an access is rejected by both the power rule and the write-protect rule, the recorded cause is the power-off code 2'b01.
- R7: An error response sets `rsp_valid_o`=1 and `rsp_err_o`=1 with `rsp_rdata_o`=0, for exactly one cycle, in the cycle after acceptance.
- R8: A permitted request drives `slv_valid_o` in the same cycle, with `req_ready_o` equal to `slv_ready_i`. Address, direction, privilege and write data reach the slave unchanged. The slave's response valid, error flag and read data come back unchanged.
- R9: Every rejection captures the address, master identifier, direction and cause into the status register and sets `stat_valid_o`. A later rejection overwrites the earlier record.
- R10: A `stat_clr_i` pulse returns every status field to zero. If a rejection occurs in the same cycle, the new record is kept.
- R11: After reset, the status fields are zero, no response is pending, debug mode is inactive and all power domains count as on.
- R12: Only one transaction is outstanding at a time. While a response is pending, `req_ready_o` and `slv_valid_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_mode_i | input | 1 | Debug mode request (registered) |
| pwr_on_i | input | NREG | Power-domain-on per region (registered) |
| req_valid_i | input | 1 | Upstream request valid |
| req_ready_o | output | 1 | Upstream request accepted |
| req_addr_i | input | ADDR_W | Request address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_priv_i | input | 1 | 1 = privileged access |
| req_mid_i | input | MID_W | Master identifier |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Upstream response valid |
| rsp_err_o | output | 1 | Upstream response error |
| rsp_rdata_o | output | DATA_W | Upstream read data |
| slv_valid_o | output | 1 | Forwarded request valid |
| slv_ready_i | input | 1 | Slave ready |
| slv_sel_o | output | NREG | One-hot region select |
| slv_addr_o | output | ADDR_W | Forwarded address |
| slv_write_o | output | 1 | Forwarded direction |
| slv_priv_o | output | 1 | Forwarded privilege |
| slv_wdata_o | output | DATA_W | Forwarded write data |
| slv_rsp_valid_i | input | 1 | Slave response valid |
| slv_rsp_err_i | input | 1 | Slave response error |
| slv_rdata_i | input | DATA_W | Slave read data |
| stat_clr_i | input | 1 | Write-one-to-clear pulse for status |
| stat_valid_o | output | 1 | Sticky error flag |
| stat_cause_o | output | 2 | Cause: 00 none, 01 power off, 10 write protect |
| stat_addr_o | output | ADDR_W | Captured address |
| stat_mid_o | output | MID_W | Captured master identifier |
| stat_write_o | output | 1 | Captured direction |

## Verification
Several properties are checked on every clock cycle. An accepted request that is not forwarded must produce a zero-data error response on the next cycle. The select must stay one-hot or zero. Nothing may be forwarded while a response is still owed, and a forwarded request must follow the slave's ready. The status flag must match a non-zero cause and must obey the set and clear ordering. Other behaviour can only be shown by the bench's scenarios: which master identifiers and regions are refused, the debug bypass, the power-over-protect priority, the one-cycle delay of the registered debug and power inputs, and reset treating every domain as powered.

// File: rtl/sag_pkg.sv
package sag_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_PWR  = 2'b01,
    CAUSE_WP   = 2'b10
  } cause_e;
endpackage

// File: rtl/sag_region_decode.sv
module sag_region_decode #(
  parameter int ADDR_W = 32,
  parameter int NREG   = 4,
  parameter logic [NREG*ADDR_W-1:0] BASE = '0,
  parameter logic [NREG*ADDR_W-1:0] MASK = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   sel
);
  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign hit[g] = ((addr & MASK[g*ADDR_W +: ADDR_W]) == BASE[g*ADDR_W +: ADDR_W]);
  end

  // isolate the lowest matching region
  assign sel = hit & ((~hit) + NREG'(1));
endmodule

// File: rtl/sag_access_rules.sv
module sag_access_rules
  import sag_pkg::*;
#(
  parameter int NREG        = 4,
  parameter int MID_W       = 4,
  parameter int PROT_REGION = 0,
  parameter int PROT_MID    = 1
) (
  input  logic [NREG-1:0]  sel,
  input  logic [NREG-1:0]  pwr_on,
  input  logic             dbg,
  input  logic             write,
  input  logic [MID_W-1:0] mid,
  output cause_e           cause
);
  logic pwr_off_hit;
  logic wp_hit;

  assign pwr_off_hit = |(sel & ~pwr_on);
  assign wp_hit      = write && sel[PROT_REGION] && !dbg && (mid != MID_W'(PROT_MID));

  always_comb begin
    if (pwr_off_hit)  cause = CAUSE_PWR;   // power check has priority
    else if (wp_hit)  cause = CAUSE_WP;
    else              cause = CAUSE_NONE;
  end
endmodule

// File: rtl/sag_err_status.sv
module sag_err_status
  import sag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MID_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_evt,
  input  cause_e            err_cause,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [MID_W-1:0]  err_mid,
  input  logic              err_write,
  input  logic              clr,
  output logic              valid_o,
  output logic [1:0]        cause_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [MID_W-1:0]  mid_o,
  output logic              write_o
);
  always_ff @(posedge clk) begin
    if (rst || (clr && !err_evt)) begin
      valid_o <= 1'b0;
      cause_o <= 2'b00;
      addr_o  <= '0;
      mid_o   <= '0;
      write_o <= 1'b0;
    end else if (err_evt) begin
      valid_o <= 1'b1;
      cause_o <= err_cause;
      addr_o  <= err_addr;
      mid_o   <= err_mid;
      write_o <= err_write;
    end
  end

  AST_STAT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (cause_o != 2'b00)); // R9
  AST_STAT_SET: assert property (@(posedge clk) disable iff (rst)
    err_evt |=> valid_o); // R9
  AST_STAT_CLR: assert property (@(posedge clk) disable iff (rst)
    (clr && !err_evt) |=> (!valid_o && cause_o == 2'b00)); // R10
endmodule

// File: rtl/slave_access_guard.sv
module slave_access_guard
  import sag_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int MID_W       = 4,
  parameter int NREG        = 4,
  parameter int PROT_REGION = 0,
  parameter int PROT_MID    = 1,
  parameter logic [NREG*ADDR_W-1:0] REG_BASE =
    {32'h0000_0000, 32'h0000_2000, 32'h0000_1000, 32'h0000_0000},
  parameter logic [NREG*ADDR_W-1:0] REG_MASK =
    {32'hFFFF_0000, 32'hFFFF_F000, 32'hFFFF_F000, 32'hFFFF_F000}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_mode_i,
  input  logic [NREG-1:0]   pwr_on_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              req_priv_i,
  input  logic [MID_W-1:0]  req_mid_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              slv_valid_o,
  input  logic              slv_ready_i,
  output logic [NREG-1:0]   slv_sel_o,
  output logic [ADDR_W-1:0] slv_addr_o,
  output logic              slv_write_o,
  output logic              slv_priv_o,
  output logic [DATA_W-1:0] slv_wdata_o,
  input  logic              slv_rsp_valid_i,
  input  logic              slv_rsp_err_i,
  input  logic [DATA_W-1:0] slv_rdata_i,
  input  logic              stat_clr_i,
  output logic              stat_valid_o,
  output logic [1:0]        stat_cause_o,
  output logic [ADDR_W-1:0] stat_addr_o,
  output logic [MID_W-1:0]  stat_mid_o,
  output logic              stat_write_o
);
  logic [NREG-1:0] pwr_q;
  logic            dbg_q;
  logic [NREG-1:0] sel;
  cause_e          cause;
  logic            reject;
  logic            busy;
  logic            accept;
  logic            err_evt;
  logic            err_pend_q;
  logic            fwd_pend_q;

  // registered mode inputs; domains count as powered out of reset
  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q <= '1;
      dbg_q <= 1'b0;
    end else begin
      pwr_q <= pwr_on_i;
      dbg_q <= dbg_mode_i;
    end
  end

  sag_region_decode #(
    .ADDR_W(ADDR_W), .NREG(NREG), .BASE(REG_BASE), .MASK(REG_MASK)
  ) u_dec (
    .addr(req_addr_i),
    .sel (sel)
  );

  sag_access_rules #(
    .NREG(NREG), .MID_W(MID_W), .PROT_REGION(PROT_REGION), .PROT_MID(PROT_MID)
  ) u_rules (
    .sel   (sel),
    .pwr_on(pwr_q),
    .dbg   (dbg_q),
    .write (req_write_i),
    .mid   (req_mid_i),
    .cause (cause)
  );

  assign reject  = (cause != CAUSE_NONE);
  assign busy    = err_pend_q | fwd_pend_q;
  assign req_ready_o = !busy && (reject ? 1'b1 : slv_ready_i);
  assign accept  = req_valid_i && req_ready_o;
  assign err_evt = accept && reject;

  assign slv_valid_o = req_valid_i && !busy && !reject;
  assign slv_sel_o   = sel;
  assign slv_addr_o  = req_addr_i;
  assign slv_write_o = req_write_i;
  assign slv_priv_o  = req_priv_i;
  assign slv_wdata_o = req_wdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pend_q <= 1'b0;
      fwd_pend_q <= 1'b0;
    end else begin
      err_pend_q <= err_evt;
      if (accept && !reject)  fwd_pend_q <= 1'b1;
      else if (slv_rsp_valid_i) fwd_pend_q <= 1'b0;
    end
  end

  assign rsp_valid_o = err_pend_q | (fwd_pend_q & slv_rsp_valid_i);
  assign rsp_err_o   = err_pend_q | (fwd_pend_q & slv_rsp_err_i);
  assign rsp_rdata_o = err_pend_q ? '0 : slv_rdata_i;

  sag_err_status #(.ADDR_W(ADDR_W), .MID_W(MID_W)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .err_evt  (err_evt),
    .err_cause(cause),
    .err_addr (req_addr_i),
    .err_mid  (req_mid_i),
    .err_write(req_write_i),
    .clr      (stat_clr_i),
    .valid_o  (stat_valid_o),
    .cause_o  (stat_cause_o),
    .addr_o   (stat_addr_o),
    .mid_o    (stat_mid_o),
    .write_o  (stat_write_o)
  );

  AST_ERR_RESP: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_ready_o && !slv_valid_o) |=>
      (rsp_valid_o && rsp_err_o && rsp_rdata_o == '0)); // R7
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slv_sel_o)); // R1
  AST_NO_FWD_PENDING: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |-> (!slv_valid_o && !req_ready_o)); // R12
  AST_FWD_READY: assert property (@(posedge clk) disable iff (rst)
    slv_valid_o |-> (req_ready_o == slv_ready_i)); // R8
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && rsp_err_o && rsp_rdata_o == '0 && !slv_rsp_valid_i) |=> !rsp_err_o || slv_rsp_valid_i); // R7
endmodule

// File: tb/slave_access_guard_tb_top.sv
module slave_access_guard_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int MW = 4;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dbg_mode = 1'b0;
  logic [NR-1:0] pwr_on = '1;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic req_write = 1'b0, req_priv = 1'b0;
  logic [MW-1:0] req_mid = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic slv_valid, slv_ready = 1'b1;
  logic [NR-1:0] slv_sel;
  logic [AW-1:0] slv_addr;
  logic slv_write, slv_priv;
  logic [DW-1:0] slv_wdata;
  logic slv_rsp_valid = 1'b0, slv_rsp_err = 1'b0;
  logic [DW-1:0] slv_rdata = '0;
  logic stat_clr = 1'b0, stat_valid, stat_write;
  logic [1:0] stat_cause;
  logic [AW-1:0] stat_addr;
  logic [MW-1:0] stat_mid;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  slave_access_guard dut_i (
    .clk(clk), .rst(rst), .dbg_mode_i(dbg_mode), .pwr_on_i(pwr_on),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_write_i(req_write), .req_priv_i(req_priv), .req_mid_i(req_mid),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err),
    .rsp_rdata_o(rsp_rdata), .slv_valid_o(slv_valid), .slv_ready_i(slv_ready),
    .slv_sel_o(slv_sel), .slv_addr_o(slv_addr), .slv_write_o(slv_write),
    .slv_priv_o(slv_priv), .slv_wdata_o(slv_wdata),
    .slv_rsp_valid_i(slv_rsp_valid), .slv_rsp_err_i(slv_rsp_err),
    .slv_rdata_i(slv_rdata), .stat_clr_i(stat_clr), .stat_valid_o(stat_valid),
    .stat_cause_o(stat_cause), .stat_addr_o(stat_addr), .stat_mid_o(stat_mid),
    .stat_write_o(stat_write)
  );

  // slave model: answers one cycle after a handshake; error when addr[3:0]==F
  always @(posedge clk) begin
    slv_rsp_valid <= slv_valid && slv_ready;
    slv_rsp_err   <= (slv_addr[3:0] == 4'hF);
    slv_rdata     <= slv_addr ^ 32'hA5A5_0000;
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [AW-1:0] a, input logic w,
                       input logic [MW-1:0] m, input logic p, input logic [DW-1:0] d);
    req_valid = 1'b1; req_addr = a; req_write = w; req_mid = m;
    req_priv = p; req_wdata = d;
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic [3:0]  mid;
    logic        dbg;
    logic [3:0]  pwr;
    logic        fwd;
    logic [3:0]  sel;
    logic [1:0]  cause;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0010, 1'b0, 4'd3, 1'b0, 4'hF, 1'b1, 4'b0001, 2'b00}, // R3 R1 read region0, overlap picks 0
    '{32'h0000_0010, 1'b1, 4'd1, 1'b0, 4'hF, 1'b1, 4'b0001, 2'b00}, // R3 write by mid 1
    '{32'h0000_0014, 1'b1, 4'd2, 1'b0, 4'hF, 1'b0, 4'b0001, 2'b10}, // R2
    '{32'h0000_0018, 1'b1, 4'd0, 1'b0, 4'hF, 1'b0, 4'b0001, 2'b10}, // R2
    '{32'h0000_0018, 1'b1, 4'd5, 1'b1, 4'hF, 1'b1, 4'b0001, 2'b00}, // R4
    '{32'h0000_1004, 1'b0, 4'd2, 1'b0, 4'hD, 1'b0, 4'b0010, 2'b01}, // R5 read
    '{32'h0000_2008, 1'b1, 4'd7, 1'b0, 4'hB, 1'b0, 4'b0100, 2'b01}, // R5 write
    '{32'h0000_0020, 1'b1, 4'd3, 1'b0, 4'hE, 1'b0, 4'b0001, 2'b01}, // R6
    '{32'h0000_200F, 1'b1, 4'd3, 1'b0, 4'hF, 1'b1, 4'b0100, 2'b00}, // R8 slave error
    '{32'h0000_8100, 1'b0, 4'd4, 1'b0, 4'hF, 1'b1, 4'b1000, 2'b00}, // R1
    '{32'h0002_0000, 1'b0, 4'd4, 1'b0, 4'h0, 1'b1, 4'b0000, 2'b00}, // R1 unmapped
    '{32'h0000_1FFF, 1'b0, 4'd1, 1'b0, 4'hF, 1'b1, 4'b0010, 2'b00}, // R8
    '{32'h0000_0000, 1'b1, 4'd1, 1'b1, 4'hF, 1'b1, 4'b0001, 2'b00}  // R4 R3
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    // reset with debug requested and all domains reported off
    dbg_mode = 1'b1; pwr_on = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11", "rsp_valid", 64'(rsp_valid), 64'd0);
    check("R11", "stat_valid", 64'(stat_valid), 64'd0);
    check("R11", "stat_cause", 64'(stat_cause), 64'd0);
    check("R11", "stat_addr", 64'(stat_addr), 64'd0);
    check("R11", "stat_mid", 64'(stat_mid), 64'd0);
    // first cycle: domains still on, debug still off -> write protect
    rst = 1'b0;
    drive(32'h0000_0010, 1'b1, 4'd3, 1'b0, 32'h1234);
    #1;
    check("R11 R5", "slv_valid first cycle", 64'(slv_valid), 64'd0);
    check("R11 R4", "req_ready first cycle", 64'(req_ready), 64'd1);
    @(negedge clk); req_valid = 1'b0; #1;
    check("R11", "cause after reset", 64'(stat_cause), 64'd2);
    check("R7", "err rsp", {rsp_valid, rsp_err}, 64'd3);
    check("R7", "err rdata", 64'(rsp_rdata), 64'd0);
    @(negedge clk); #1;
    check("R7", "rsp one cycle", 64'(rsp_valid), 64'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      dbg_mode = VECS[i].dbg; pwr_on = VECS[i].pwr; stat_clr = 1'b1;
      @(negedge clk);
      stat_clr = 1'b0;
      drive(VECS[i].addr, VECS[i].wr, VECS[i].mid, i[0], 32'hD000_0000 | i);
      #1;
      check("R1 R2 R5", "slv_valid", 64'(slv_valid), 64'(VECS[i].fwd));
      check("R8", "req_ready", 64'(req_ready), 64'd1);
      if (VECS[i].fwd) begin
        check("R1", "slv_sel", 64'(slv_sel), 64'(VECS[i].sel));
        check("R8", "slv fields", {slv_addr, slv_write, slv_priv},
              {VECS[i].addr, VECS[i].wr, i[0]});
        check("R8", "slv_wdata", 64'(slv_wdata), 64'(32'hD000_0000 | i));
      end
      @(negedge clk); req_valid = 1'b0; #1;
      check("R7 R8", "rsp_valid", 64'(rsp_valid), 64'd1);
      check("R12", "busy ready", 64'(req_ready), 64'd0);
      if (VECS[i].fwd) begin
        check("R8", "rsp_err", 64'(rsp_err), 64'(VECS[i].addr[3:0] == 4'hF));
        check("R8", "rsp_rdata", 64'(rsp_rdata), 64'(VECS[i].addr ^ 32'hA5A5_0000));
        check("R9", "stat_valid clean", 64'(stat_valid), 64'd0);
      end else begin
        check("R7", "rsp err/data", {rsp_err, rsp_rdata}, {1'b1, 32'h0});
        check("R9", "stat_valid", 64'(stat_valid), 64'd1);
        check("R2 R5 R6", "stat_cause", 64'(stat_cause), 64'(VECS[i].cause));
        check("R9", "stat record", {stat_addr, stat_mid, stat_write},
              {VECS[i].addr, VECS[i].mid, VECS[i].wr});
      end
    end

    // R9 overwrite: two rejections back to back, no clear
    @(negedge clk); dbg_mode = 1'b0; pwr_on = 4'hF;
    @(negedge clk); drive(32'h0000_0040, 1'b1, 4'd6, 1'b0, 0);
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk); drive(32'h0000_0044, 1'b1, 4'd9, 1'b0, 0);
    @(negedge clk); req_valid = 1'b0; #1;
    check("R9", "overwrite addr", 64'(stat_addr), 64'h44);
    check("R9", "overwrite mid", 64'(stat_mid), 64'd9);

    // R10 clear alone
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0; #1;
    check("R10", "cleared", {stat_valid, stat_cause, stat_addr, stat_mid, stat_write}, 64'd0);
    // R10 set wins over clear
    drive(32'h0000_0048, 1'b1, 4'd2, 1'b0, 0); stat_clr = 1'b1;
    @(negedge clk); req_valid = 1'b0; stat_clr = 1'b0; #1;
    check("R10", "set wins valid", 64'(stat_valid), 64'd1);
    check("R10", "set wins addr", 64'(stat_addr), 64'h48);

    // R12: request held while forwarded access is pending
    @(negedge clk); drive(32'h0000_1010, 1'b0, 4'd2, 1'b0, 0);
    @(negedge clk); #1;
    check("R12", "slv_valid while pending", 64'(slv_valid), 64'd0);
    check("R12", "req_ready while pending", 64'(req_ready), 64'd0);
    @(negedge clk); #1;
    check("R12", "accepted after", 64'(slv_valid && req_ready), 64'd1);
    @(negedge clk); req_valid = 1'b0;

    // R8: slave not ready stalls a permitted access; R2: rejection ignores it
    @(negedge clk); slv_ready = 1'b0; drive(32'h0000_1020, 1'b0, 4'd2, 1'b0, 0); #1;
    check("R8", "stall ready", 64'(req_ready), 64'd0);
    check("R8", "stall valid", 64'(slv_valid), 64'd1);
    req_addr = 32'h0000_0024; req_write = 1'b1; #1;
    check("R2", "reject ready w/o slave", 64'(req_ready), 64'd1);
    check("R2", "reject not fwd", 64'(slv_valid), 64'd0);
    @(negedge clk); req_valid = 1'b0; slv_ready = 1'b1; #1;
    check("R2", "stall reject rsp", {rsp_valid, rsp_err}, 64'd3);
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule